// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block arbitrates a bank of interrupt and exception sources (32 by default) and performs the entry step of interrupt handling. It keeps a per-source enable mask and a global interrupt-enable bit. Each cycle it is idle, it looks at the sources that are eligible and picks the lowest index. It then raises an entry request that carries the chosen index and the handler-table address. The handler table sits at a fixed base, and a source's slot is the base plus its index, counted in words.

In the cycle it accepts a source, the controller clears the global enable and that source's mask bit. From then on only a software mask write can enable that source again. The request stays up until the state-saving logic acknowledges it, and no new source is taken in the meantime.

The source classes are fixed by index:
- Index 1 is a non-maskable hardware error and is always taken.
- Indices 0 and 2 to 5 are synchronous exceptions. They need only their mask bit.
- Index 6 and indices 7 upward need both their mask bit and the global enable.

A software interrupt command names its own vector index and is taken whatever the global enable and mask hold. The set-enable and clear-enable commands are obeyed only outside user mode.

Top module: `vic_entry_ctrl`

## Requirements
- R1: After reset `entry_req` is 0, `gie` is 0 and `mask_q` is all ones.
- R2: When several sources are eligible in the same idle cycle, the lowest index is accepted.
- R3: One clock edge after acceptance, `entry_req` is 1, `entry_idx` holds the accepted index and `vec_addr` equals `TABLE_BASE` plus that index.
- R4: Acceptance clears `gie`. A set-enable command in the accepting cycle loses to this clear.
- R5: Acceptance clears bit `entry_idx` of `mask_q`. A source whose mask bit is 0 is not taken until a mask write sets the bit again (index 1 excepted).
- R6: Index 1 is taken when `gie` is 0 and its mask bit is 0.
- R7: Indices 0, 2, 3, 4 and 5 are taken when `gie` is 0, provided their mask bit is 1.
- R8: Indices 6 to NUM_SRC-1 are taken only when both `gie` and their mask bit are 1.
- R9: `entry_req`, `entry_idx` and `vec_addr` hold until `ack`. Pending lines and software commands seen while a request is up are not taken, and a one-cycle software command in that window is lost.
- R10: `set_ie` sets `gie` and `clr_ie` clears it, only when `user_mode` is 0. If both are asserted together, the clear wins.
- R11: `swi_req` with index `swi_idx` is taken regardless of `gie` and of the mask.
- R12: `mask_wr` loads `mask_wdata` into `mask_q`. In the accepting cycle, the clear of the accepted bit wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | NUM_SRC | Level pending line per source |
| swi_req | input | 1 | Software interrupt command |
| swi_idx | input | IDX_W | Vector index given by the software command |
| set_ie | input | 1 | Set-global-enable command |
| clr_ie | input | 1 | Clear-global-enable command |
| user_mode | input | 1 | 1 when the processor runs in user mode |
| mask_wr | input | 1 | Software write strobe for the mask |
| mask_wdata | input | NUM_SRC | Mask value to write, 1 enables a source |
| ack | input | 1 | State save done, ends the entry |
| entry_req | output | 1 | Entry in progress, save of state requested |
| entry_idx | output | IDX_W | Accepted source index |
| vec_addr | output | ADDR_W | Handler-table word address for the accepted index |
| gie | output | 1 | Global interrupt enable |
| mask_q | output | NUM_SRC | Current per-source mask |

## Verification
The bench drives the three source classes with the global enable both low and high. A design that mixed up the classes would take a platform line with interrupts disabled, or drop the non-maskable error.

Several tests check one-cycle collisions:
- A set-enable in the accepting cycle must lose, or interrupts would stay enabled inside the handler.
- A mask write in the accepting cycle must lose, or the handler could be re-entered at once.
- Set and clear together must clear.

Other tests target source selection and handshake state:
- Simultaneous lines must resolve to the lowest index.
- A line or software command raised while a request is up must not replace the held index or vector.
- A source taken once must stay blocked until software rewrites its mask bit.

// File: rtl/vic_pkg.sv
package vic_pkg;
   // Indices of the synchronous exceptions (0 and 2..5)
   parameter logic [63:0] VIC_SYNC_DEFAULT = 64'h0000_0000_0000_003D;
   parameter int VIC_MAX_SRC = 64;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } vic_state_t;
endpackage

// File: rtl/vic_gie_reg.sv
module vic_gie_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_cmd,
   input  logic clr_cmd,
   input  logic priv_ok,
   input  logic entry_clr,
   output logic gie
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         gie <= 1'b0;
      else if (entry_clr)
         gie <= 1'b0;
      else if (priv_ok && clr_cmd)
         gie <= 1'b0;
      else if (priv_ok && set_cmd)
         gie <= 1'b1;
   end

   // R10: in user mode the enable can never rise
   assert_no_user_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!priv_ok && !entry_clr) |=> $stable(gie));
   // R4: an entry always leaves the enable low
   assert_entry_clears_gie_R4: assert property (@(posedge clk) disable iff (!rst_n)
      entry_clr |=> !gie);
endmodule

// File: rtl/vic_mask_reg.sv
module vic_mask_reg #(
   parameter int          NUM_SRC  = 32,
   parameter logic [63:0] MASK_RST = '1,
   localparam int         IDX_W    = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [NUM_SRC-1:0] wdata,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   clr_idx,
   output logic [NUM_SRC-1:0] mask
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask[i] <= MASK_RST[i];
         else if (clr_en && (clr_idx == IDX_W'(i)))
            mask[i] <= 1'b0;
         else if (wr)
            mask[i] <= wdata[i];
      end
   end

   // R5: the accepted bit reads zero after entry
   assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> !mask[$past(clr_idx)]);
   // R12: without write or clear the mask keeps its value
   assert_mask_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !clr_en) |=> $stable(mask));
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
   parameter int  NUM_SRC = 32,
   localparam int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] cand,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand[i]) idx = IDX_W'(i);
      end
   end
   assign hit = |cand;

   // R2: the chosen bit is set and nothing below it is set
   always_comb begin
      if (hit) begin
         assert_pick_lowest_R2: assert (cand[idx] && ((cand & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0));
      end
   end
endmodule

// File: rtl/vic_entry_ctrl.sv
module vic_entry_ctrl
   import vic_pkg::*;
#(
   parameter int          NUM_SRC    = 32,
   parameter int          ADDR_W     = 32,
   parameter logic [31:0] TABLE_BASE = 32'h0000_0100,
   parameter int          NMI_IDX    = 1,
   parameter logic [63:0] SYNC_MAP   = VIC_SYNC_DEFAULT,
   parameter logic [63:0] MASK_RST   = '1,
   localparam int         IDX_W      = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_pend,
   input  logic               swi_req,
   input  logic [IDX_W-1:0]   swi_idx,
   input  logic               set_ie,
   input  logic               clr_ie,
   input  logic               user_mode,
   input  logic               mask_wr,
   input  logic [NUM_SRC-1:0] mask_wdata,
   input  logic               ack,
   output logic               entry_req,
   output logic [IDX_W-1:0]   entry_idx,
   output logic [ADDR_W-1:0]  vec_addr,
   output logic               gie,
   output logic [NUM_SRC-1:0] mask_q
);
   if (NUM_SRC < 8 || NUM_SRC > VIC_MAX_SRC) begin : g_bad_num
      $error("vic_entry_ctrl: NUM_SRC must lie in 8..64");
   end
   if (NMI_IDX < 0 || NMI_IDX >= NUM_SRC) begin : g_bad_nmi
      $error("vic_entry_ctrl: NMI_IDX out of range");
   end
   if (ADDR_W < IDX_W || ADDR_W > 32) begin : g_bad_addr
      $error("vic_entry_ctrl: ADDR_W must lie in IDX_W..32");
   end

   vic_state_t         state_q;
   logic [NUM_SRC-1:0] elig;
   logic [NUM_SRC-1:0] swi_vec;
   logic [NUM_SRC-1:0] cand;
   logic               pick_hit;
   logic [IDX_W-1:0]   pick_idx;
   logic               accept;

   // Eligibility per source class
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      if (i == NMI_IDX) begin : g_nmi
         assign elig[i] = src_pend[i];
      end else if (SYNC_MAP[i]) begin : g_sync
         assign elig[i] = src_pend[i] & mask_q[i];
      end else begin : g_plat
         assign elig[i] = src_pend[i] & mask_q[i] & gie;
      end
   end

   assign swi_vec = swi_req ? (NUM_SRC'(1) << swi_idx) : '0;
   assign cand    = (state_q == ST_IDLE) ? (elig | swi_vec) : '0;

   vic_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .cand (cand),
      .hit  (pick_hit),
      .idx  (pick_idx)
   );

   assign accept = pick_hit;

   vic_gie_reg u_gie (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_cmd   (set_ie),
      .clr_cmd   (clr_ie),
      .priv_ok   (!user_mode),
      .entry_clr (accept),
      .gie       (gie)
   );

   vic_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (mask_wr),
      .wdata   (mask_wdata),
      .clr_en  (accept),
      .clr_idx (pick_idx),
      .mask    (mask_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         entry_idx <= '0;
         vec_addr  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q   <= ST_WAIT;
               entry_idx <= pick_idx;
               vec_addr  <= TABLE_BASE[ADDR_W-1:0] + ADDR_W'(pick_idx);
            end
            ST_WAIT: if (ack) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign entry_req = (state_q == ST_WAIT);

   // R9: request, index and vector hold until acknowledged
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_req && !ack) |=> (entry_req && $stable(entry_idx) && $stable(vec_addr)));
   // R3: vector matches index for the whole request
   assert_vec_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      entry_req |-> (vec_addr == TABLE_BASE[ADDR_W-1:0] + ADDR_W'(entry_idx)));
   // R4: a fresh request always sees interrupts disabled
   assert_rise_gie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(entry_req) |-> !gie);
   // R6: the non-maskable source is taken from idle
   assert_nmi_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!entry_req && src_pend[NMI_IDX]) |=> entry_req);
endmodule

// File: tb/sim_vic_entry_ctrl.sv
module sim_vic_entry_ctrl;
   localparam int N  = 32;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_pend = '0;
   logic          swi_req = 1'b0;
   logic [IW-1:0] swi_idx = '0;
   logic          set_ie = 1'b0;
   logic          clr_ie = 1'b0;
   logic          user_mode = 1'b0;
   logic          mask_wr = 1'b0;
   logic [N-1:0]  mask_wdata = '0;
   logic          ack = 1'b0;
   logic          entry_req;
   logic [IW-1:0] entry_idx;
   logic [31:0]   vec_addr;
   logic          gie;
   logic [N-1:0]  mask_q;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   vic_entry_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .swi_req(swi_req), .swi_idx(swi_idx),
      .set_ie(set_ie), .clr_ie(clr_ie), .user_mode(user_mode), .mask_wr(mask_wr),
      .mask_wdata(mask_wdata), .ack(ack), .entry_req(entry_req), .entry_idx(entry_idx),
      .vec_addr(vec_addr), .gie(gie), .mask_q(mask_q)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_ack();
      ack = 1'b1;
      tick();
      ack = 1'b0;
      chk("R9 ack ends request", 64'(entry_req), 0);
   endtask

   task automatic t_reset();
      chk("R1 req after reset", 64'(entry_req), 0);
      chk("R1 gie after reset", 64'(gie), 0);
      chk("R1 mask after reset", 64'(mask_q), 64'hFFFF_FFFF);
   endtask

   task automatic t_sync_exc();
      src_pend[3] = 1'b1;
      tick();
      chk("R7 sync taken with gie 0", 64'(entry_req), 1);
      chk("R3 index 3", 64'(entry_idx), 3);
      chk("R3 vector 3", 64'(vec_addr), 64'h103);
      chk("R5 mask bit 3 cleared", 64'(mask_q), 64'hFFFF_FFF7);
      src_pend[3] = 1'b0;
      tick(); tick();
      chk("R9 request held", 64'(entry_req), 1);
      do_ack();
      src_pend[3] = 1'b1;
      tick(); tick();
      chk("R5 masked source not retaken", 64'(entry_req), 0);
      src_pend[3] = 1'b0;
   endtask

   task automatic t_platform();
      src_pend[9] = 1'b1;
      tick(); tick();
      chk("R8 platform blocked by gie 0", 64'(entry_req), 0);
      set_ie = 1'b1;
      tick();
      set_ie = 1'b0;
      chk("R10 set command", 64'(gie), 1);
      tick();
      chk("R8 platform taken", 64'(entry_idx), 9);
      chk("R8 platform request", 64'(entry_req), 1);
      chk("R4 gie cleared on entry", 64'(gie), 0);
      src_pend[9] = 1'b0;
      do_ack();
      set_ie = 1'b1;
      src_pend[9] = 1'b1;
      tick();
      set_ie = 1'b0;
      tick(); tick();
      chk("R8 masked platform ignored with gie 1", 64'(entry_req), 0);
      src_pend[9] = 1'b0;
      clr_ie = 1'b1;
      tick();
      clr_ie = 1'b0;
      chk("R10 clear command", 64'(gie), 0);
   endtask

   task automatic t_priv();
      user_mode = 1'b1;
      set_ie = 1'b1;
      tick();
      chk("R10 set ignored in user mode", 64'(gie), 0);
      user_mode = 1'b0;
      tick();
      chk("R10 set in system mode", 64'(gie), 1);
      user_mode = 1'b1;
      set_ie = 1'b0;
      clr_ie = 1'b1;
      tick();
      chk("R10 clear ignored in user mode", 64'(gie), 1);
      user_mode = 1'b0;
      set_ie = 1'b1;
      tick();
      chk("R10 clear wins over set", 64'(gie), 0);
      clr_ie = 1'b0;
      tick();
      set_ie = 1'b0;
      chk("R10 gie set again", 64'(gie), 1);
   endtask

   task automatic t_priority();
      src_pend[20] = 1'b1;
      src_pend[12] = 1'b1;
      set_ie = 1'b1;
      tick();
      set_ie = 1'b0;
      chk("R2 lowest of 12 and 20", 64'(entry_idx), 12);
      chk("R4 set loses to entry clear", 64'(gie), 0);
      src_pend[0] = 1'b1;
      tick();
      chk("R9 new line ignored while busy", 64'(entry_idx), 12);
      chk("R9 vector held while busy", 64'(vec_addr), 64'h10C);
      do_ack();
      tick();
      chk("R2 sync index 0 next", 64'(entry_idx), 0);
      chk("R3 vector 0", 64'(vec_addr), 64'h100);
      src_pend = '0;
      do_ack();
   endtask

   task automatic t_nmi();
      mask_wr = 1'b1;
      mask_wdata = '0;
      tick();
      mask_wr = 1'b0;
      chk("R12 mask write", 64'(mask_q), 0);
      src_pend[1] = 1'b1;
      tick();
      chk("R6 nmi taken masked with gie 0", 64'(entry_req), 1);
      chk("R3 vector 1", 64'(vec_addr), 64'h101);
      src_pend[1] = 1'b0;
      do_ack();
   endtask

   task automatic t_swi();
      swi_req = 1'b1;
      swi_idx = 5'd6;
      tick();
      swi_req = 1'b0;
      chk("R11 software entry", 64'(entry_idx), 6);
      chk("R11 software vector", 64'(vec_addr), 64'h106);
      swi_req = 1'b1;
      swi_idx = 5'd7;
      tick();
      swi_req = 1'b0;
      chk("R9 software command ignored while busy", 64'(entry_idx), 6);
      do_ack();
      tick();
      chk("R9 lost software command", 64'(entry_req), 0);
   endtask

   task automatic t_mask_collide();
      mask_wr = 1'b1;
      mask_wdata = '1;
      tick();
      chk("R12 mask restored", 64'(mask_q), 64'hFFFF_FFFF);
      src_pend[4] = 1'b1;
      tick();
      mask_wr = 1'b0;
      chk("R12 clear wins over write", 64'(mask_q), 64'hFFFF_FFEF);
      chk("R7 index 4 taken", 64'(entry_idx), 4);
      src_pend[4] = 1'b0;
      do_ack();
   endtask

   task automatic t_top_index();
      set_ie = 1'b1;
      tick();
      set_ie = 1'b0;
      src_pend[31] = 1'b1;
      tick();
      chk("R3 index 31", 64'(entry_idx), 31);
      chk("R3 vector 31", 64'(vec_addr), 64'h11F);
      src_pend[31] = 1'b0;
      do_ack();
   endtask

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_sync_exc();
      t_platform();
      t_priv();
      t_priority();
      t_nmi();
      t_swi();
      t_mask_collide();
      t_top_index();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule